// File: doc/BRIEF.md
# Burst-Write Symbol Record Queue

This block sits between a bit-plane context modeller and a binary arithmetic encoder. The modeller works on two samples per producer cycle and hands over anywhere from zero to six symbol records at once. The encoder consumes at most one record per clock. The queue runs on the encoder's clock, which is twice the producer's rate. In the cycles where the producer has something to hand over, it presents a write strobe, a record count and six record lanes. The queue appends the counted lanes in lane order, lane 0 first, and presents the oldest stored record to the encoder with a valid/ready handshake.

Each record is an opaque 9-bit word. By convention it carries a 5-bit context label in bits [8:4], the decision bit in bit 3 and a 3-bit pass tag in bits [2:0]. The queue never decodes these fields. Storage is a ten-entry ring. A combinational stop output tells the producer that the free space, measured at the start of the cycle, could not absorb a worst-case burst of six records. A write presented while stop is high is discarded, so a stored record is never overwritten.

Top module: `sym_piso_buf`

## Requirements
- R1: While reset is active and on the first cycle after it is released, rd_valid and stop are both low.
- R2: A write with wr_valid high, stop low and wr_count N in 0..6 appends lanes 0..N-1 of wr_data, in that order. Lane i occupies bits [9i+8:9i]. Each stored record is returned bit for bit.
- R3: rd_data shows the oldest stored record whenever rd_valid is high. A record is removed exactly when rd_valid and rd_ready are high at a clock edge. While rd_ready is low, rd_valid and rd_data stay unchanged unless a write lands.
- R4: rd_valid is high exactly when at least one record is stored.
- R5: stop is high exactly when more than 4 records are stored, meaning fewer than 6 of the 10 entries are free. It depends only on the occupancy at the start of the cycle.
- R6: A write presented while stop is high stores nothing.
- R7: A write with wr_count of 7 is discarded entirely.
- R8: A write with wr_count of 0 leaves the contents unchanged.
- R9: rd_ready asserted while the queue is empty has no effect on later contents or ordering.
- R10: A write and a read in the same cycle both take effect. The pop is applied to the old head and the new records join at the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Encoder-rate clock, twice the producer rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_valid | input | 1 | Producer presents a write this cycle |
| wr_count | input | 3 | Number of valid lanes, 0..6 |
| wr_data | input | 54 | Six 9-bit record lanes, lane 0 in the low bits |
| stop | output | 1 | Producer must hold off; free space is below one full burst |
| rd_valid | output | 1 | rd_data holds a stored record |
| rd_data | output | 9 | Oldest stored record |
| rd_ready | input | 1 | Encoder takes the record on this edge |

## Verification
A corrupted occupancy counter shows at the ports within one cycle. stop then flips at the wrong fill level, or rd_valid falls while records remain. A wrong tail pointer or lane enable shows up as a wrong rd_data value at the moment that record reaches the head. That can be up to ten reads later. For this reason the bench compares every cycle against an arithmetic model of the queue contents. A head pointer that fails to wrap at the tenth entry shows as a stale record right after the first lap of the ring. The sweeps are long enough to wrap the ring many times for every write count and read pattern.

// File: rtl/sym_piso_pkg.sv
`timescale 1ns/1ps
package sym_piso_pkg;

  localparam int unsigned REC_W_DEF = 9;
  localparam int unsigned LANES_DEF = 6;
  localparam int unsigned DEPTH_DEF = 10;

  // Modulo add for a ring whose size need not be a power of two.
  // Both operands are assumed below depth.
  function automatic int unsigned ring_add(input int unsigned base,
                                           input int unsigned inc,
                                           input int unsigned depth);
    int unsigned sum;
    sum = base + inc;
    if (sum >= depth) sum = sum - depth;
    return sum;
  endfunction

endpackage

// File: rtl/sym_piso_rstsync.sv
`timescale 1ns/1ps
module sym_piso_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/sym_piso_ctrl.sv
`timescale 1ns/1ps
module sym_piso_ctrl
  import sym_piso_pkg::*;
#(
  parameter  int unsigned DEPTH  = DEPTH_DEF,
  parameter  int unsigned LANES  = LANES_DEF,
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned LCNT_W = $clog2(LANES + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_valid,
  input  logic [LCNT_W-1:0]             wr_count,
  input  logic                          rd_ready,
  output logic                          stop,
  output logic                          rd_valid,
  output logic [LANES-1:0]              lane_we,
  output logic [LANES-1:0][PTR_W-1:0]   lane_addr,
  output logic [PTR_W-1:0]              rd_addr
);

  localparam int unsigned STOP_LVL = DEPTH - LANES;

  logic [CNT_W-1:0]  count_q, count_d;
  logic [PTR_W-1:0]  wptr_q, wptr_d;
  logic [PTR_W-1:0]  rptr_q, rptr_d;
  logic              burst_ok;
  logic              accept;
  logic              pop;
  logic              upd_en;
  logic [LCNT_W-1:0] add_cnt;

  // Outputs decoded from the registered occupancy only.
  assign stop     = count_q > CNT_W'(STOP_LVL);
  assign rd_valid = count_q != '0;
  assign rd_addr  = rptr_q;

  // Next-state logic
  always_comb begin
    burst_ok = wr_count <= LCNT_W'(LANES);
    accept   = wr_valid && !stop && burst_ok;
    pop      = rd_valid && rd_ready;
    add_cnt  = accept ? wr_count : '0;
    upd_en   = accept || pop;
    count_d  = count_q + CNT_W'(add_cnt) - CNT_W'(pop);
    wptr_d   = PTR_W'(ring_add(32'(wptr_q), 32'(add_cnt), DEPTH));
    rptr_d   = pop ? PTR_W'(ring_add(32'(rptr_q), 32'd1, DEPTH)) : rptr_q;
  end

  // Per-lane target slot and enable
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_addr[i] = PTR_W'(ring_add(32'(wptr_q), 32'(i), DEPTH));
    assign lane_we[i]   = accept && (LCNT_W'(i) < wr_count);
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      wptr_q  <= '0;
      rptr_q  <= '0;
    end else if (upd_en) begin
      count_q <= count_d;
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
    end
  end

endmodule

// File: rtl/sym_piso_store.sv
`timescale 1ns/1ps
module sym_piso_store
  import sym_piso_pkg::*;
#(
  parameter  int unsigned DEPTH = DEPTH_DEF,
  parameter  int unsigned LANES = LANES_DEF,
  parameter  int unsigned REC_W = REC_W_DEF,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [LANES-1:0]            lane_we,
  input  logic [LANES-1:0][PTR_W-1:0] lane_addr,
  input  logic [LANES*REC_W-1:0]      lane_data,
  input  logic [PTR_W-1:0]            rd_addr,
  output logic [REC_W-1:0]            rd_data
);

  logic [DEPTH-1:0][REC_W-1:0] ent_all;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic             hit;
    logic [REC_W-1:0] din;
    logic [REC_W-1:0] ent_q;

    // Lanes of one write target distinct slots, so at most one hits.
    always_comb begin
      hit = 1'b0;
      din = '0;
      for (int i = 0; i < LANES; i++) begin
        if (lane_we[i] && (lane_addr[i] == PTR_W'(e))) begin
          hit = 1'b1;
          din = lane_data[i*REC_W +: REC_W];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (hit) begin
        ent_q <= din;
      end
    end

    assign ent_all[e] = ent_q;
  end

  assign rd_data = ent_all[rd_addr];

endmodule

// File: rtl/sym_piso_buf.sv
`timescale 1ns/1ps
module sym_piso_buf
  import sym_piso_pkg::*;
#(
  parameter  int unsigned DEPTH  = DEPTH_DEF,
  parameter  int unsigned LANES  = LANES_DEF,
  parameter  int unsigned REC_W  = REC_W_DEF,
  localparam int unsigned LCNT_W = $clog2(LANES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  input  logic [LCNT_W-1:0]      wr_count,
  input  logic [LANES*REC_W-1:0] wr_data,
  output logic                   stop,
  output logic                   rd_valid,
  output logic [REC_W-1:0]       rd_data,
  input  logic                   rd_ready
);

  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic                        rst_q_n;
  logic [LANES-1:0]            lane_we;
  logic [LANES-1:0][PTR_W-1:0] lane_addr;
  logic [PTR_W-1:0]            rd_addr;

  sym_piso_rstsync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_q_n)
  );

  sym_piso_ctrl #(
    .DEPTH (DEPTH),
    .LANES (LANES)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .wr_valid  (wr_valid),
    .wr_count  (wr_count),
    .rd_ready  (rd_ready),
    .stop      (stop),
    .rd_valid  (rd_valid),
    .lane_we   (lane_we),
    .lane_addr (lane_addr),
    .rd_addr   (rd_addr)
  );

  sym_piso_store #(
    .DEPTH (DEPTH),
    .LANES (LANES),
    .REC_W (REC_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .lane_we   (lane_we),
    .lane_addr (lane_addr),
    .lane_data (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data)
  );

endmodule

// File: rtl/sym_piso_chk.sv
`timescale 1ns/1ps
module sym_piso_chk #(
  parameter  int unsigned LANES  = 6,
  parameter  int unsigned REC_W  = 9,
  localparam int unsigned LCNT_W = $clog2(LANES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [LCNT_W-1:0] wr_count,
  input logic              stop,
  input logic              rd_valid,
  input logic [REC_W-1:0]  rd_data,
  input logic              rd_ready
);

  // R1
  reset_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!rd_valid && !stop));

  // R2
  first_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && wr_valid && wr_count != '0 && wr_count <= LCNT_W'(LANES))
      |=> rd_valid);

  // R3
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !wr_valid) |=> (rd_valid && $stable(rd_data)));

  // R4
  stay_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && !wr_valid) |=> !rd_valid);

  // R5
  stop_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> rd_valid);

  // R6
  stop_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !rd_ready) |=> stop);

  // R7
  oversize_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_count > LCNT_W'(LANES) && !rd_ready)
      |=> ($stable(rd_valid) && $stable(rd_data) && $stable(stop)));

  // R8
  zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_count == '0 && !rd_ready)
      |=> ($stable(rd_valid) && $stable(rd_data) && $stable(stop)));

endmodule

bind sym_piso_buf sym_piso_chk #(
  .LANES (LANES),
  .REC_W (REC_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .wr_valid (wr_valid),
  .wr_count (wr_count),
  .stop     (stop),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .rd_ready (rd_ready)
);

// File: tb/sym_piso_buf_bench.sv
`timescale 1ns/1ps
module sym_piso_buf_bench;

  localparam int DEPTH = 10;
  localparam int LANES = 6;
  localparam int REC_W = 9;

  logic                   clk;
  logic                   rst_n;
  logic                   wr_valid;
  logic [2:0]             wr_count;
  logic [LANES*REC_W-1:0] wr_data;
  logic                   stop;
  logic                   rd_valid;
  logic [REC_W-1:0]       rd_data;
  logic                   rd_ready;

  int          n_chk;
  int          n_fail;
  logic [15:0] lfsr;
  logic [8:0]  model_q[$];
  string       cur_tag;

  sym_piso_buf u_sym_piso_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_count (wr_count),
    .wr_data  (wr_data),
    .stop     (stop),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .rd_ready (rd_ready)
  );

  // 200 MHz
  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [8:0] next_rec();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[8:0] ^ lfsr[15:7];
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // One fast cycle: check outputs against the model, then drive inputs
  // and advance the model to the state after the coming edge.
  task automatic step(input logic v, input int c, input logic r);
    logic st;
    logic pop;
    logic acc;
    logic [8:0] rec;
    @(negedge clk);
    st = model_q.size() > (DEPTH - LANES);
    chk(cur_tag, "stop (R5)", 32'(stop), 32'(st));
    chk(cur_tag, "rd_valid (R4)", 32'(rd_valid), 32'(model_q.size() != 0));
    if (model_q.size() != 0)
      chk(cur_tag, "rd_data (R3)", 32'(rd_data), 32'(model_q[0]));
    pop = (model_q.size() != 0) && r;
    acc = v && !st && (c <= LANES);
    wr_valid = v;
    wr_count = 3'(c);
    rd_ready = r;
    if (pop) void'(model_q.pop_front());
    for (int i = 0; i < LANES; i++) begin
      rec = next_rec();
      wr_data[i*REC_W +: REC_W] = rec;
      if (acc && i < c) model_q.push_back(rec);
    end
  endtask

  function automatic logic ready_pat(input int p, input int k);
    case (p)
      0:       return 1'b1;
      1:       return k[0];
      2:       return (k % 3) == 0;
      default: return lfsr[3] & lfsr[9];
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R3 watchdog expired before the run completed");
    summary();
    $finish;
  end

  initial begin
    n_chk    = 0;
    n_fail   = 0;
    lfsr     = 16'hACE1;
    cur_tag  = "R1";
    rst_n    = 1'b0;
    wr_valid = 1'b0;
    wr_count = 3'd0;
    wr_data  = '0;
    rd_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "rd_valid in reset", 32'(rd_valid), 32'd0);
    chk("R1", "stop in reset", 32'(stop), 32'd0);
    rst_n = 1'b1;
    repeat (4) step(1'b0, 0, 1'b0);

    // Fill to the stop level: 3 then 2 records, no reads.
    cur_tag = "R2";
    step(1'b1, 3, 1'b0);
    step(1'b0, 0, 1'b0);
    cur_tag = "R5";
    step(1'b1, 2, 1'b0);
    step(1'b0, 0, 1'b0);
    chk("R5", "stop at 5 stored", 32'(stop), 32'd1);
    // Burst while stopped is dropped.
    cur_tag = "R6";
    step(1'b1, 6, 1'b0);
    step(1'b0, 0, 1'b0);
    // Drain in order.
    cur_tag = "R3";
    repeat (7) step(1'b0, 0, 1'b1);
    chk("R3", "empty after drain", 32'(rd_valid), 32'd0);

    // Oversized count is dropped.
    cur_tag = "R7";
    step(1'b1, 7, 1'b0);
    step(1'b0, 0, 1'b0);
    chk("R7", "still empty", 32'(rd_valid), 32'd0);

    // Zero-count writes around stored data.
    cur_tag = "R8";
    step(1'b1, 2, 1'b0);
    step(1'b1, 0, 1'b0);
    step(1'b1, 0, 1'b0);
    repeat (3) step(1'b0, 0, 1'b1);

    // Reads requested while empty, then a normal write and drain.
    cur_tag = "R9";
    repeat (3) step(1'b0, 0, 1'b1);
    step(1'b1, 4, 1'b1);
    repeat (6) step(1'b0, 0, 1'b1);
    chk("R9", "empty after drain", 32'(rd_valid), 32'd0);

    // Simultaneous write and read every cycle, stop throttling.
    cur_tag = "R10";
    for (int k = 0; k < 80; k++) step(1'b1, (k % 6) + 1, 1'b1);
    repeat (12) step(1'b0, 0, 1'b1);

    // Sweep every count against every read pattern, producer at half rate.
    cur_tag = "R2";
    for (int c = 0; c < 8; c++) begin
      for (int p = 0; p < 4; p++) begin
        for (int k = 0; k < 48; k++) step((k % 2) == 0, c, ready_pat(p, k));
        repeat (12) step(1'b0, 0, 1'b1);
      end
    end

    // Mixed counts with an irregular reader.
    cur_tag = "R3";
    for (int k = 0; k < 400; k++) step(lfsr[0], int'(lfsr[6:4]), ready_pat(3, k));
    repeat (12) step(1'b0, 0, 1'b1);

    summary();
    $finish;
  end

endmodule